// File: doc/BRIEF.md
# Byte-Port ALU Command Sequencer

This block sits between a byte-wide host port and an arithmetic unit. It runs one arithmetic operation per host transaction. Each transaction has four fixed phases. The host writes a command byte. The host then writes a 16-bit operand, low byte first. The sequencer starts the arithmetic unit, waits for it to finish, and returns the 16-bit result, low byte first. Last, it returns one packed flag byte. A single ready line tells the host when the port will take the next access. The line drops after every accepted access and rises again once the next phase can proceed.

The operand phase is never skipped. A command that needs no operand still takes a dummy operand, and the arithmetic unit ignores it. A command byte with any reserved bit set is thrown away, and the sequencer waits for a fresh command byte. A mode output tells the host whether the current phase moves a single byte or a two-byte word.

Top module: `host_alu_sequencer`

## Requirements
- R1: While reset is held, `rqm`, `alu_go` and `wide_mode` are low. In the first cycle after reset is released, `rqm` rises in the command phase with `wide_mode` low.
- R2: The command byte holds the opcode in bits 3:0 and the carry-in in bit 4. Bits 7:5 must be zero. An accepted command drives `alu_op` and `alu_cin` with these fields.
- R3: A command byte with any of bits 7:5 set is discarded. It raises no `alu_go`, and the next byte written is decoded as a new command byte.
- R4: After a valid command, the host must write two operand bytes, low byte first, whatever the opcode. `alu_operand` then equals {second byte, first byte}. `alu_go` is high for exactly one cycle, the cycle after the second byte is accepted.
- R5: An accepted host access drives `rqm` low in the next cycle. Outside execution, `rqm` rises again one cycle after that.
- R6: A host access is ignored when `rqm` is low, and also when its direction does not match the phase. Such an access changes neither the phase nor the captured operand.
- R7: After `alu_done`, `rqm` rises and the host reads the 16-bit `alu_result` as two bytes, low byte first. `alu_done` is taken into account only during execution.
- R8: The flag byte reads as {1, 1, S1, S0, CA, ZA, OV1, OV0} from bit 7 down to bit 0. The lower six bits come from `alu_flags`, whose bits 5 to 0 are S1, S0, CA, ZA, OV1 and OV0.
- R9: `wide_mode` is low in the command and flag phases. It is high in the operand, execution and result phases.
- R10: After the flag byte is read, the sequencer returns to the command phase, and the next transaction starts from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_rd | input | 1 | Host read strobe, consumes the presented byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte presented to the host in read phases |
| rqm | output | 1 | Port ready for the next host access |
| wide_mode | output | 1 | High while the phase moves a two-byte word |
| alu_go | output | 1 | One-cycle start pulse to the arithmetic unit |
| alu_op | output | 4 | Opcode field of the accepted command |
| alu_cin | output | 1 | Carry-in field of the accepted command |
| alu_operand | output | 16 | Assembled operand |
| alu_done | input | 1 | Arithmetic unit has finished; result and flags are valid |
| alu_result | input | 16 | Accumulator value after the operation |
| alu_flags | input | 6 | Flags S1, S0, CA, ZA, OV1, OV0 (bit 5 down to bit 0) |

## Verification
Every accepted access takes effect at the next rising edge. At the falling edge that follows, `rqm` is already low, and it must be high one falling edge later. `alu_go` appears at the first falling edge after the high operand byte is accepted. After `alu_done` is sampled, the result is due two edges later, once `rqm` has risen. The bench drives and samples only on falling edges and counts edges from each accepted access. It runs every opcode with both carry values and every combination of the six flag bits. Rejected command bytes, strobes sent while `rqm` is low and strobes in the wrong direction are each checked through `wide_mode`, `rqm`, `alu_go` and the operand that is later passed to the arithmetic unit.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
   typedef enum logic [2:0] {
      PH_CMD  = 3'd0,
      PH_OPND = 3'd1,
      PH_EXEC = 3'd2,
      PH_RES  = 3'd3,
      PH_FLAG = 3'd4
   } phase_e;

   function automatic logic phase_is_wide(phase_e p);
      return (p == PH_OPND) || (p == PH_EXEC) || (p == PH_RES);
   endfunction
endpackage

// File: rtl/hcs_phase_ctrl.sv
module hcs_phase_ctrl
   import hcs_pkg::*;
#(
   parameter int NB    = 2,
   parameter int IDX_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic             cmd_bad,
   input  logic             alu_done,
   output phase_e           phase,
   output logic [IDX_W-1:0] byte_idx,
   output logic             rqm,
   output logic             wr_acc,
   output logic             rd_acc,
   output logic             done_acc,
   output logic             alu_go
);
   phase_e           phase_q;
   logic [IDX_W-1:0] idx_q;
   logic             rqm_q;
   logic             go_q;
   logic             last_byte;

   assign wr_acc    = rqm_q && host_wr && ((phase_q == PH_CMD) || (phase_q == PH_OPND));
   assign rd_acc    = rqm_q && host_rd && ((phase_q == PH_RES) || (phase_q == PH_FLAG));
   assign done_acc  = (phase_q == PH_EXEC) && alu_done && !go_q;
   assign last_byte = (idx_q == IDX_W'(NB - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_CMD;
         idx_q   <= '0;
         rqm_q   <= 1'b0;
         go_q    <= 1'b0;
      end else begin
         go_q <= 1'b0;
         if (wr_acc || rd_acc)
            rqm_q <= 1'b0;
         else if (phase_q != PH_EXEC)
            rqm_q <= 1'b1;
         unique case (phase_q)
            PH_CMD: begin
               if (wr_acc && !cmd_bad) begin
                  phase_q <= PH_OPND;
                  idx_q   <= '0;
               end
            end
            PH_OPND: begin
               if (wr_acc) begin
                  if (last_byte) begin
                     phase_q <= PH_EXEC;
                     idx_q   <= '0;
                     go_q    <= 1'b1;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            PH_EXEC: begin
               if (done_acc) begin
                  phase_q <= PH_RES;
                  idx_q   <= '0;
               end
            end
            PH_RES: begin
               if (rd_acc) begin
                  if (last_byte) begin
                     phase_q <= PH_FLAG;
                     idx_q   <= '0;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            PH_FLAG: begin
               if (rd_acc) phase_q <= PH_CMD;
            end
            default: phase_q <= PH_CMD;
         endcase
      end
   end

   assign phase    = phase_q;
   assign byte_idx = idx_q;
   assign rqm      = rqm_q;
   assign alu_go   = go_q;

   a_r5_rqm_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc || rd_acc) |=> !rqm_q);
   a_r5_rqm_returns: assert property (@(posedge clk) disable iff (!rst_n)
      (!rqm_q && phase_q != PH_EXEC) |=> rqm_q);
   a_r4_go_single: assert property (@(posedge clk) disable iff (!rst_n)
      go_q |=> !go_q);
   a_r6_idle_when_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!rqm_q && phase_q != PH_EXEC) |=> $stable(phase_q) && $stable(idx_q));
   a_r3_bad_cmd_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CMD && wr_acc && cmd_bad) |=> (phase_q == PH_CMD) && !go_q);
   a_r10_back_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FLAG && rd_acc) |=> (phase_q == PH_CMD));
endmodule

// File: rtl/hcs_cmd_capture.sv
module hcs_cmd_capture
   import hcs_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int DATA_W = 16,
   parameter int OP_W   = 4,
   parameter int NB     = 2,
   parameter int IDX_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_acc,
   input  phase_e            phase,
   input  logic [IDX_W-1:0]  byte_idx,
   input  logic [BYTE_W-1:0] wdata,
   output logic              cmd_bad,
   output logic [OP_W-1:0]   alu_op,
   output logic              alu_cin,
   output logic [DATA_W-1:0] alu_operand
);
   localparam int RSV_W = BYTE_W - OP_W - 1;

   logic [OP_W-1:0]   op_q;
   logic              cin_q;
   logic [BYTE_W-1:0] lane_q [NB];

   generate
      if (RSV_W > 0) begin : g_rsv
         assign cmd_bad = |wdata[BYTE_W-1:OP_W+1];
      end else begin : g_no_rsv
         assign cmd_bad = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q  <= '0;
         cin_q <= 1'b0;
      end else if (wr_acc && phase == PH_CMD && !cmd_bad) begin
         op_q  <= wdata[OP_W-1:0];
         cin_q <= wdata[OP_W];
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            lane_q[b] <= '0;
         else if (wr_acc && phase == PH_OPND && byte_idx == IDX_W'(b))
            lane_q[b] <= wdata;
      end
      assign alu_operand[b*BYTE_W +: BYTE_W] = lane_q[b];
   end

   assign alu_op  = op_q;
   assign alu_cin = cin_q;

   a_r4_operand_held: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EXEC && $past(phase) == PH_EXEC) |-> $stable(alu_operand));
   a_r2_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_CMD) |=> $stable(op_q) && $stable(cin_q));
endmodule

// File: rtl/hcs_result_mux.sv
module hcs_result_mux
   import hcs_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int DATA_W = 16,
   parameter int FLAG_W = 6,
   parameter int NB     = 2,
   parameter int IDX_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_acc,
   input  logic [DATA_W-1:0] alu_result,
   input  logic [FLAG_W-1:0] alu_flags,
   input  phase_e            phase,
   input  logic [IDX_W-1:0]  byte_idx,
   output logic [BYTE_W-1:0] rdata
);
   localparam int FILL_W = BYTE_W - FLAG_W;

   logic [BYTE_W-1:0] res_lane [NB];
   logic [FLAG_W-1:0] flg_q;
   logic [BYTE_W-1:0] flag_byte;

   for (genvar b = 0; b < NB; b++) begin : g_res
      always_ff @(posedge clk) begin
         if (!rst_n)
            res_lane[b] <= '0;
         else if (done_acc)
            res_lane[b] <= alu_result[b*BYTE_W +: BYTE_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      flg_q <= '0;
      else if (done_acc) flg_q <= alu_flags;
   end

   generate
      if (FILL_W > 0) begin : g_fill
         assign flag_byte = {{FILL_W{1'b1}}, flg_q};
      end else begin : g_nofill
         assign flag_byte = flg_q[BYTE_W-1:0];
      end
   endgenerate

   always_comb begin
      unique case (phase)
         PH_RES:  rdata = res_lane[byte_idx];
         PH_FLAG: rdata = flag_byte;
         default: rdata = '0;
      endcase
   end

   a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RES && $past(phase) == PH_RES) |-> $stable(flg_q));
   a_r8_flag_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_FLAG) |-> (rdata[BYTE_W-1:FLAG_W] == '1));
endmodule

// File: rtl/host_alu_sequencer.sv
module host_alu_sequencer
   import hcs_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   parameter int OP_W   = 4,
   parameter int FLAG_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [BYTE_W-1:0] host_rdata,
   output logic              rqm,
   output logic              wide_mode,
   output logic              alu_go,
   output logic [OP_W-1:0]   alu_op,
   output logic              alu_cin,
   output logic [DATA_W-1:0] alu_operand,
   input  logic              alu_done,
   input  logic [DATA_W-1:0] alu_result,
   input  logic [FLAG_W-1:0] alu_flags
);
   localparam int NB    = DATA_W / BYTE_W;
   localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

   initial begin
      assert (DATA_W % BYTE_W == 0) else $error("DATA_W must be a multiple of BYTE_W");
      assert (OP_W + 1 <= BYTE_W)   else $error("command fields exceed a byte");
      assert (FLAG_W <= BYTE_W)     else $error("flags exceed a byte");
   end

   phase_e           phase;
   logic [IDX_W-1:0] byte_idx;
   logic             wr_acc, rd_acc, done_acc, cmd_bad;

   hcs_phase_ctrl #(.NB(NB), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .cmd_bad(cmd_bad), .alu_done(alu_done), .phase(phase),
      .byte_idx(byte_idx), .rqm(rqm), .wr_acc(wr_acc), .rd_acc(rd_acc),
      .done_acc(done_acc), .alu_go(alu_go)
   );

   hcs_cmd_capture #(.BYTE_W(BYTE_W), .DATA_W(DATA_W), .OP_W(OP_W),
                     .NB(NB), .IDX_W(IDX_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .phase(phase),
      .byte_idx(byte_idx), .wdata(host_wdata), .cmd_bad(cmd_bad),
      .alu_op(alu_op), .alu_cin(alu_cin), .alu_operand(alu_operand)
   );

   hcs_result_mux #(.BYTE_W(BYTE_W), .DATA_W(DATA_W), .FLAG_W(FLAG_W),
                    .NB(NB), .IDX_W(IDX_W)) u_res (
      .clk(clk), .rst_n(rst_n), .done_acc(done_acc), .alu_result(alu_result),
      .alu_flags(alu_flags), .phase(phase), .byte_idx(byte_idx),
      .rdata(host_rdata)
   );

   assign wide_mode = phase_is_wide(phase);

   a_r9_narrow_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (rqm && !wide_mode && host_rd) |=> (phase != PH_RES));
   a_r4_go_after_opnd: assert property (@(posedge clk) disable iff (!rst_n)
      alu_go |-> (phase == PH_EXEC));
endmodule

// File: tb/host_alu_sequencer_tb_top.sv
`timescale 1ns/1ps
module host_alu_sequencer_tb_top;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        rqm, wide_mode, alu_go, alu_cin;
   logic [3:0]  alu_op;
   logic [15:0] alu_operand;
   logic        alu_done = 1'b0;
   logic [15:0] alu_result = '0;
   logic [5:0]  alu_flags = '0;

   int checks = 0, fails = 0;
   int go_cnt = 0, dbl_go = 0, pend = 0;
   logic        prev_go = 1'b0;
   logic [3:0]  cap_op;
   logic        cap_cin;
   logic [15:0] cap_opnd;

   always #10 clk = ~clk;

   host_alu_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .rqm(rqm),
      .wide_mode(wide_mode), .alu_go(alu_go), .alu_op(alu_op),
      .alu_cin(alu_cin), .alu_operand(alu_operand), .alu_done(alu_done),
      .alu_result(alu_result), .alu_flags(alu_flags)
   );

   function automatic logic [15:0] model_res(logic [3:0] op, logic cin, logic [15:0] d);
      return 16'(d * 3 + op * 257 + cin);
   endfunction

   // arithmetic unit stand-in
   always @(negedge clk) begin
      alu_done = 1'b0;
      if (!rst_n) begin
         pend = 0;
      end else if (alu_go) begin
         go_cnt++;
         if (prev_go) dbl_go++;
         cap_op = alu_op; cap_cin = alu_cin; cap_opnd = alu_operand;
         pend = LAT;
      end else if (pend > 0) begin
         pend--;
         if (pend == 0) begin
            alu_done   = 1'b1;
            alu_result = model_res(cap_op, cap_cin, cap_opnd);
            alu_flags  = cap_opnd[15:10];
         end
      end
      prev_go = alu_go;
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_rqm();
      while (!rqm) @(negedge clk);
   endtask

   task automatic host_write(input logic [7:0] b, input logic wide);
      wait_rqm();
      chk(wide_mode == wide, "R9", wide_mode, wide);
      host_wr = 1'b1; host_wdata = b;
      @(negedge clk);
      host_wr = 1'b0;
      chk(rqm == 1'b0, "R5", rqm, 0);
   endtask

   task automatic host_read(output logic [7:0] b, input logic wide);
      wait_rqm();
      chk(wide_mode == wide, "R9", wide_mode, wide);
      b = host_rdata;
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      chk(rqm == 1'b0, "R5", rqm, 0);
   endtask

   task automatic txn(input logic [7:0] cmd, input logic [15:0] d);
      logic [7:0] lo, hi, fl;
      int g0;
      logic [15:0] er;
      g0 = go_cnt;
      host_write(cmd, 1'b0);
      host_write(d[7:0], 1'b1);
      host_write(d[15:8], 1'b1);
      host_read(lo, 1'b1);
      host_read(hi, 1'b1);
      host_read(fl, 1'b0);
      er = model_res(cmd[3:0], cmd[4], d);
      chk(go_cnt == g0 + 1, "R4", go_cnt - g0, 1);
      chk(cap_op == cmd[3:0] && cap_cin == cmd[4], "R2", {cap_cin, cap_op}, cmd[4:0]);
      chk(cap_opnd == d, "R4", cap_opnd, d);
      chk({hi, lo} == er, "R7", {hi, lo}, er);
      chk(fl == {2'b11, d[15:10]}, "R8", fl, {2'b11, d[15:10]});
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] junk;
      int g0;
      repeat (3) @(negedge clk);
      chk(!rqm && !alu_go && !wide_mode, "R1", {rqm, alu_go, wide_mode}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rqm == 1'b1 && !wide_mode, "R1", {rqm, wide_mode}, 2);

      // every opcode with both carries
      for (int op = 0; op < 16; op++)
         for (int c = 0; c < 2; c++)
            txn(8'((c << 4) | op), 16'(op * 4660 + c * 777 + 16'h1357));

      // every flag combination
      for (int f = 0; f < 64; f++)
         txn(8'(f & 31), {6'(f), 10'(f * 7 + 3)});

      // R3: reserved bits set
      for (int k = 1; k < 8; k++) begin
         g0 = go_cnt;
         host_write(8'((k << 5) | 9), 1'b0);
         @(negedge clk);
         chk(rqm && !wide_mode, "R3", {rqm, wide_mode}, 2);
         chk(go_cnt == g0, "R3", go_cnt - g0, 0);
      end
      txn(8'h16, 16'hBEEF);
      chk(cap_op == 4'h6 && cap_cin, "R3", {cap_cin, cap_op}, 8'h16);

      // R6: accesses while rqm low and in the wrong direction
      host_write(8'h03, 1'b0);
      host_wr = 1'b1; host_wdata = 8'hEE;          // rqm is low this cycle
      @(negedge clk);
      host_wr = 1'b0;
      chk(rqm == 1'b1, "R5", rqm, 1);
      host_rd = 1'b1;                              // read during a write phase
      @(negedge clk);
      host_rd = 1'b0;
      chk(rqm == 1'b1 && wide_mode, "R6", {rqm, wide_mode}, 3);
      host_write(8'h34, 1'b1);
      host_write(8'h12, 1'b1);
      host_wr = 1'b1; host_wdata = 8'hFF;          // writes during execution
      repeat (2) @(negedge clk);
      host_wr = 1'b0;
      host_read(junk, 1'b1);
      chk(alu_operand == 16'h1234, "R6", alu_operand, 16'h1234);
      chk(junk == model_res(4'h3, 1'b0, 16'h1234) % 256, "R7", junk,
          model_res(4'h3, 1'b0, 16'h1234) % 256);
      host_wr = 1'b1; host_wdata = 8'h55;          // write during result phase
      @(negedge clk);
      host_wr = 1'b0;
      host_read(junk, 1'b1);
      chk(junk == model_res(4'h3, 1'b0, 16'h1234) / 256, "R6", junk,
          model_res(4'h3, 1'b0, 16'h1234) / 256);
      host_read(junk, 1'b0);
      @(negedge clk);
      chk(rqm && !wide_mode, "R10", {rqm, wide_mode}, 2);
      txn(8'h0B, 16'h8001);

      chk(dbl_go == 0, "R4", dbl_go, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule